// File: doc/BRIEF.md
# Manchester Subcarrier Response Encoder

This block produces the load-modulation enable for a contactless tag's reply. It runs on a clock with one tick per carrier cycle. It takes response bytes over a valid/ready handshake and sends a frame. The frame is a start pattern, then the bytes least significant bit first, then a two-byte inverted CRC-16 over those bytes, then an end pattern. The end pattern is the start pattern played backwards. Every bit is Manchester coded: it has two half-bit slots, one "on" and one "off".

There are two signalling modes. In single-subcarrier mode an "on" slot carries a square wave at the carrier divided by `LO_DIV`, and an "off" slot leaves the load switch open. In dual-subcarrier mode the "off" slot carries a second square wave at the carrier divided by `HI_DIV`, so the output switches between two frequencies. The data rate is also selectable. At the fast rate a half-bit lasts `HALF_CYC` carrier cycles. At the slow rate it lasts `SLOW_MULT` times as long. Both selects are captured when the frame starts.

Top module: `subc_resp_encoder`

## Requirements
- R1: With no frame in progress, `mod_out` is 0 and `in_ready` is 1. This is also the state after reset.
- R2: A frame starts when a byte is accepted while idle. `dual_sc` and `fast_rate` are sampled at that acceptance, and changes to them during the frame have no effect on `mod_out`.
- R3: A half-bit slot lasts `HALF_CYC` cycles when `fast_rate` was 1 and `HALF_CYC*SLOW_MULT` cycles when it was 0. The first slot begins in the cycle after the accepting clock edge.
- R4: In an "on" slot, `mod_out` is high for the first `LO_DIV/2` cycles of every `LO_DIV`-cycle period, with periods counted from the start of the slot. In single mode an "off" slot drives `mod_out` to 0.
- R5: In dual mode (`dual_sc`=1), an "off" slot is high for the first `HI_DIV/2` cycles of every `HI_DIV`-cycle period, counted from the start of the slot.
- R6: A data bit 0 is sent as "on" then "off", and a bit 1 as "off" then "on". Bits go bit 0 first, and bytes go in the order they were accepted.
- R7: The start pattern is eight slots: off, off, off, on, on, on, off, on.
- R8: After the data come two CRC bytes, each coded like data. The CRC is preset to 0xFFFF and uses the reflected polynomial 0x8408. It processes the data bits least significant first. Its one's complement is sent low byte first.
- R9: After the CRC come eight end slots: on, off, on, on, on, off, off, off. From the next cycle the block is idle as in R1.
- R10: After the byte flagged `in_last` is accepted, `in_ready` stays 0 until the frame ends. At most one byte waits behind the byte being sent.
- R11: If the current byte finishes and no next byte is waiting, the CRC follows at once, covering only the bytes already sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-cycle clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| in_valid | input | 1 | Response byte offered |
| in_ready | output | 1 | Encoder takes the offered byte at this edge |
| in_data | input | 8 | Response byte |
| in_last | input | 1 | Offered byte is the final data byte |
| dual_sc | input | 1 | 1 selects two-subcarrier signalling, 0 selects on/off keying |
| fast_rate | input | 1 | 1 selects the fast bit rate, 0 the slow one |
| mod_out | output | 1 | Load-modulation enable |

## Verification
`mod_out` is fixed cycle by cycle from the moment of acceptance. So any wrong internal state shows up as soon as the affected slot is sent. A slot or phase counter that is off by one shifts every later edge and shows within one half-bit. A wrong data bit or CRC bit shows within the half-bit of that bit. A buffer or sequencing fault shows as wrong bits, the wrong frame length, or `in_ready` rising while the frame is still running. The bench compares the full waveform of every frame against a model built from these rules. It sweeps both modes, both rates, one to three bytes, mid-frame toggling of the selects, and underrun.

// File: rtl/sre_pkg.sv
package sre_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SOF  = 3'd1,
        PH_DATA = 3'd2,
        PH_CRCL = 3'd3,
        PH_CRCH = 3'd4,
        PH_EOF  = 3'd5
    } sre_phase_e;

    // CRC-16 (reflected form, processed bit 0 first)
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;

    // Start pattern, bit i is slot i (1 = subcarrier on); the end pattern reads it backwards
    localparam logic [7:0] SOF_SLOTS = 8'hB8;

endpackage

// File: rtl/sre_crc.sv
module sre_crc
    import sre_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);

    logic [15:0] acc;

    always_comb begin
        acc = crc_in ^ {8'h00, data_in};
        for (int i = 0; i < 8; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ CRC_POLY_REV) : (acc >> 1);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/sre_subc.sv
module sre_subc #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic on
);

    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] CNT_LAST = DW'(DIV - 1);
    localparam logic [DW-1:0] CNT_HALF = DW'(DIV / 2);
    localparam logic [DW-1:0] CNT_ONE  = DW'(1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || (cnt_q == CNT_LAST)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_ONE;
        end
        on = (cnt_q < CNT_HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_SUBC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/sre_seq.sv
module sre_seq
    import sre_pkg::*;
#(
    parameter int HALF_CYC  = 256,
    parameter int SLOW_MULT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       dual_sc,
    input  logic       fast_rate,
    output logic       in_ready,
    output logic       active,
    output logic       half_on,
    output logic       half_end,
    output logic       dual_q
);

    localparam int HL_MAX = HALF_CYC * SLOW_MULT;
    localparam int CW     = $clog2(HL_MAX + 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(HL_MAX - 1);
    localparam logic [CW-1:0] CYC_ONE   = CW'(1);

    typedef struct packed {
        sre_phase_e    phase;
        logic [CW-1:0] cyc;
        logic [3:0]    half;
        logic [7:0]    shreg;
        logic [7:0]    hold;
        logic          hold_full;
        logic          last_seen;
        logic [15:0]   crc;
        logic          dual;
        logic          fast;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic        take;
    logic        seg_end;
    logic        cur_bit;
    logic [3:0]  last_half;
    logic [15:0] crc_seed;
    logic [15:0] crc_next;

    assign crc_seed = (s_q.phase == PH_IDLE) ? CRC_PRESET : s_q.crc;

    sre_crc u_crc (
        .crc_in  (crc_seed),
        .data_in (in_data),
        .crc_out (crc_next)
    );

    always_comb begin
        s_d = s_q;

        active   = (s_q.phase != PH_IDLE);
        in_ready = (s_q.phase == PH_IDLE) ||
                   (((s_q.phase == PH_SOF) || (s_q.phase == PH_DATA)) &&
                    !s_q.hold_full && !s_q.last_seen);
        take     = in_valid && in_ready;

        last_half = ((s_q.phase == PH_SOF) || (s_q.phase == PH_EOF)) ? 4'd7 : 4'd15;
        half_end  = active && (s_q.cyc == (s_q.fast ? FAST_LAST : SLOW_LAST));
        seg_end   = half_end && (s_q.half == last_half);

        cur_bit = s_q.shreg[s_q.half[3:1]];
        case (s_q.phase)
            PH_IDLE: half_on = 1'b0;
            PH_SOF:  half_on = SOF_SLOTS[s_q.half[2:0]];
            PH_EOF:  half_on = SOF_SLOTS[3'd7 - s_q.half[2:0]];
            default: half_on = s_q.half[0] ? cur_bit : ~cur_bit;
        endcase

        // slot timing
        if (active) begin
            if (half_end) begin
                s_d.cyc  = '0;
                s_d.half = seg_end ? 4'd0 : (s_q.half + 4'd1);
            end else begin
                s_d.cyc = s_q.cyc + CYC_ONE;
            end
        end

        // byte intake
        if (take) begin
            s_d.crc       = crc_next;
            s_d.last_seen = in_last;
            if (s_q.phase == PH_IDLE) begin
                s_d.phase     = PH_SOF;
                s_d.cyc       = '0;
                s_d.half      = 4'd0;
                s_d.shreg     = in_data;
                s_d.hold_full = 1'b0;
                s_d.dual      = dual_sc;
                s_d.fast      = fast_rate;
            end else begin
                s_d.hold      = in_data;
                s_d.hold_full = 1'b1;
            end
        end

        // segment sequencing
        if (seg_end) begin
            case (s_q.phase)
                PH_SOF: s_d.phase = PH_DATA;
                PH_DATA: begin
                    if (s_q.hold_full) begin
                        s_d.shreg     = s_q.hold;
                        s_d.hold_full = 1'b0;
                    end else if (take) begin
                        s_d.shreg     = in_data;
                        s_d.hold_full = 1'b0;
                    end else begin
                        s_d.shreg = ~s_q.crc[7:0];
                        s_d.phase = PH_CRCL;
                    end
                end
                PH_CRCL: begin
                    s_d.shreg = ~s_q.crc[15:8];
                    s_d.phase = PH_CRCH;
                end
                PH_CRCH: s_d.phase = PH_EOF;
                PH_EOF: begin
                    s_d.phase     = PH_IDLE;
                    s_d.last_seen = 1'b0;
                    s_d.hold_full = 1'b0;
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dual_q = s_q.dual;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (s_d.phase != PH_IDLE)) |=> ($stable(s_q.dual) && $stable(s_q.fast))); // R2

    AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        half_end |=> (s_q.cyc == '0)); // R3

    AST_START_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ((s_q.phase == PH_SOF) && (s_q.half == 4'd0) && (s_q.cyc == '0))); // R7

    AST_EOF_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_EOF) && seg_end) |=> (!active && in_ready)); // R9

    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (active && s_q.last_seen) |-> !in_ready); // R10

endmodule

// File: rtl/subc_resp_encoder.sv
module subc_resp_encoder
    import sre_pkg::*;
#(
    parameter int LO_DIV    = 32,
    parameter int HI_DIV    = 28,
    parameter int HALF_CYC  = 256,
    parameter int SLOW_MULT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       dual_sc,
    input  logic       fast_rate,
    output logic       mod_out
);

    localparam int N_SUBC = 2;
    localparam int SUBC_DIV [N_SUBC] = '{LO_DIV, HI_DIV};

    logic              active;
    logic              half_on;
    logic              half_end;
    logic              dual_q;
    logic              sc_restart;
    logic [N_SUBC-1:0] sc_on;

    sre_seq #(
        .HALF_CYC  (HALF_CYC),
        .SLOW_MULT (SLOW_MULT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .dual_sc   (dual_sc),
        .fast_rate (fast_rate),
        .in_ready  (in_ready),
        .active    (active),
        .half_on   (half_on),
        .half_end  (half_end),
        .dual_q    (dual_q)
    );

    // both subcarriers restart their phase at every slot boundary
    assign sc_restart = half_end | ~active;

    generate
        for (genvar g = 0; g < N_SUBC; g++) begin : g_subc
            sre_subc #(
                .DIV (SUBC_DIV[g])
            ) u_div (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (sc_restart),
                .on      (sc_on[g])
            );
        end
    endgenerate

    assign mod_out = active & (half_on ? sc_on[0] : (dual_q & sc_on[1]));

endmodule

// File: tb/subc_resp_encoder_tb_top.sv
`timescale 1ns/1ps
module subc_resp_encoder_tb_top;

    localparam int T_LO = 8;
    localparam int T_HI = 6;
    localparam int T_HC = 16;
    localparam int T_SM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       dual_sc = 1'b0;
    logic       fast_rate = 1'b0;
    logic       mod_out;

    int checks = 0;
    int errors = 0;

    bit        halves [0:255];
    int        nh;
    logic [7:0] fdata [0:7];
    bit        last_done;
    bit        cur_dual;
    int        hl;

    always #2.5 clk = ~clk;

    subc_resp_encoder #(
        .LO_DIV    (T_LO),
        .HI_DIV    (T_HI),
        .HALF_CYC  (T_HC),
        .SLOW_MULT (T_SM)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .dual_sc   (dual_sc),
        .fast_rate (fast_rate),
        .mod_out   (mod_out)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                bit fb = c[0] ^ fdata[i][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    function automatic void add_byte(logic [7:0] v);
        for (int b = 0; b < 8; b++) begin
            halves[nh] = ~v[b]; nh++;
            halves[nh] = v[b];  nh++;
        end
    endfunction

    function automatic void build(int n);
        bit [0:7] sof_seq = 8'b00011101;
        bit [0:7] eof_seq = 8'b10111000;
        logic [15:0] c;
        nh = 0;
        for (int i = 0; i < 8; i++) begin halves[nh] = sof_seq[i]; nh++; end
        for (int i = 0; i < n; i++) add_byte(fdata[i]);
        c = ~model_crc(n);
        add_byte(c[7:0]);
        add_byte(c[15:8]);
        for (int i = 0; i < 8; i++) begin halves[nh] = eof_seq[i]; nh++; end
    endfunction

    function automatic bit exp_mod(int t);
        int  k  = t % hl;
        bit  lo = (k % T_LO) < (T_LO / 2);
        bit  hi = (k % T_HI) < (T_HI / 2);
        return halves[t / hl] ? lo : (cur_dual & hi);
    endfunction

    task automatic push(logic [7:0] b, bit l);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        if (l) last_done = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_frame(int n, bit dual, bit fast, bit close_last, bit toggle, int pat);
        int L;
        int mism = 0;
        int first_t = -1;
        int fa = 0;
        int fe = 0;
        int rdy_bad = 0;
        int seg_h;
        string seg;
        for (int i = 0; i < n; i++) begin
            if (pat == 0) fdata[i] = 8'((i * 29) + (n * 53) + (dual ? 8'h3C : 8'hA5) + (fast ? 7 : 0));
            else fdata[i] = (i == 0) ? 8'h00 : ((i == 1) ? 8'hFF : 8'h80);
        end
        build(n);
        cur_dual  = dual;
        hl        = fast ? T_HC : T_HC * T_SM;
        L         = nh * hl;
        last_done = 1'b0;
        dual_sc   = dual;
        fast_rate = fast;
        push(fdata[0], close_last && (n == 1));
        fork
            begin
                for (int i = 1; i < n; i++) push(fdata[i], close_last && (i == n - 1));
            end
            begin
                for (int t = 0; t < L; t++) begin
                    bit e = exp_mod(t);
                    if (mod_out !== e) begin
                        mism++;
                        if (first_t < 0) begin first_t = t; fa = int'(mod_out); fe = int'(e); end
                    end
                    if (last_done && in_ready) rdy_bad++;
                    if (toggle && (t == L / 2)) begin
                        dual_sc   = ~dual_sc;
                        fast_rate = ~fast_rate;
                    end
                    @(negedge clk);
                end
            end
        join
        seg_h = (first_t < 0) ? 0 : first_t / hl;
        if (seg_h < 8) seg = "R7 start";
        else if (seg_h < 8 + 16 * n) seg = "R6 data";
        else if (seg_h < 8 + 16 * (n + 2)) seg = "R8 crc";
        else seg = "R9 end";
        check(mism == 0, dual ? "R5 R3" : "R4 R3",
              $sformatf("%s%s %s n=%0d fast=%0d first mismatch t=%0d (mod_out)",
                        toggle ? "R2 " : "", close_last ? "" : "R11", seg, n, fast, first_t),
              fa, fe);
        check((in_ready === 1'b1) && (mod_out === 1'b0), "R9",
              $sformatf("idle after %0d cycles, {in_ready,mod_out}", L),
              int'({in_ready, mod_out}), 2);
        if (close_last)
            check(rdy_bad == 0, "R10", "cycles with in_ready high after last byte", rdy_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mod_out === 1'b0, "R1", "mod_out after reset", int'(mod_out), 0);
        check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        repeat (10) @(negedge clk);
        check(mod_out === 1'b0, "R1", "mod_out idle without input", int'(mod_out), 0);

        for (int d = 0; d < 2; d++)
            for (int f = 0; f < 2; f++)
                for (int n = 1; n <= 3; n++)
                    run_frame(n, bit'(d), bit'(f), 1'b1, (n == 2), 0);

        run_frame(3, 1'b0, 1'b1, 1'b1, 1'b0, 1);
        run_frame(3, 1'b1, 1'b1, 1'b1, 1'b1, 1);
        // R11 underrun: no last flag, source stops
        run_frame(2, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        run_frame(1, 1'b1, 1'b0, 1'b0, 1'b1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule